// File: doc/BRIEF.md
# Seconds Timer and Clock Control Register

This block pairs an 8-bit control register with a free-running seconds counter. The counter runs from a 32768 Hz reference clock and advances only while the oscillator-running input is high. Each time it wraps, it raises a seconds flag in the register, which runs in the system clock domain. The register also holds a bit that keeps the reference oscillator running through power-down, an enable for the seconds interrupt, and a 5-bit frequency select code. The frequency select code is passed to the clock synthesis logic, which lies outside this block.

When the enable bit is set, the seconds flag is merged into the external interrupt 1 request. The seconds interrupt therefore uses the same request line as that pin. Software writes the whole register in one cycle and can read it back at any time. Writes are accepted on every cycle, so the write port has no back-pressure. Two inputs return the register to its reset value: an asynchronous external reset and a synchronous watchdog overflow pulse.

Top module: `sec_clock_ctrl`

## Requirements
- R1: With `wr_en` high at a rising `clk` edge, the register takes `wr_data`, apart from the rule in R5. The fields are: bit 7 keeps the oscillator running in power-down (`osc_keep`), bit 6 is the seconds interrupt enable, bit 5 is the seconds flag and bits 4:0 are the frequency select code (`fsel`). `rd_data` always shows the register.
- R2: The register is 0x0D after `rst` is asserted. It is also 0x0D one `clk` edge after `wdt_ovf` is sampled high, and this takes priority over a write.
- R3: While `osc_run` is high, the counter wraps on every 2^CNT_W-th rising edge of `ref_clk`. Each wrap sets the seconds flag within SYNC_STAGES+2 `clk` cycles. No earlier `ref_clk` edge sets it.
- R4: Once set, the seconds flag stays set until software writes 0 to bit 5. The passage of time and further wraps do not clear it.
- R5: Writing 1 to bit 5 sets the flag. If a wrap arrives on the same cycle as a write of 0, the flag is set.
- R6: `int1_req` equals `ext_int1` OR (bit 6 AND bit 5).
- R7: While `osc_run` is low, `ref_clk` edges do not advance the counter and cannot set the flag.
- R8: A reserved frequency select code is stored as written. `fsel_reserved` is high exactly when `fsel[4:2]` is not 3'b010, 3'b011 or 3'b100. All four values of `fsel[1:0]` are defined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (register) clock |
| rst | input | 1 | Asynchronous external reset, active high |
| wdt_ovf | input | 1 | Watchdog overflow pulse, synchronous to clk |
| ref_clk | input | 1 | 32768 Hz reference clock |
| osc_run | input | 1 | Reference oscillator is running |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| ext_int1 | input | 1 | External interrupt 1 request |
| rd_data | output | 8 | Register contents |
| osc_keep | output | 1 | Keep the oscillator running in power-down |
| fsel | output | 5 | Frequency select code |
| fsel_reserved | output | 1 | Selected code is reserved |
| int1_req | output | 1 | Merged interrupt 1 request |

## Verification
If the register state is wrong, it shows on `rd_data` and on the decoded outputs on the next sample after the write. That covers a wrong reset value, a lost field and a flag cleared by hardware. If the counter state is wrong, the fault stays hidden until the next wrap. A counter that is off by one or that runs while the oscillator is halted only shows when the flag rises early, late or not at all. So the bench counts reference edges exactly up to the wrap point and checks the flag on both sides of it.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int REG_W = 8;
  localparam int B_KEEP = 7;
  localparam int B_SEN = 6;
  localparam int B_FLAG = 5;
  localparam int FSEL_W = 5;
  localparam logic [REG_W-1:0] RESET_VAL = 8'h0D;

  function automatic logic fsel_is_reserved(input logic [FSEL_W-1:0] code);
    return !(code[4:2] == 3'b010 || code[4:2] == 3'b011 || code[4:2] == 3'b100);
  endfunction
endpackage

// File: rtl/sec_tick_counter.sv
module sec_tick_counter #(
  parameter int CNT_W = 15
) (
  input  logic ref_clk,
  input  logic rst,
  input  logic osc_run,
  output logic tick_tgl
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge ref_clk or posedge rst) begin
    if (rst) begin
      cnt <= '0;
      tick_tgl <= 1'b0;
    end else if (osc_run) begin
      cnt <= cnt + 1'b1;
      if (&cnt) tick_tgl <= ~tick_tgl;
    end
  end

  // R7
  cnt_hold_chk: assert property (@(posedge ref_clk) disable iff (rst)
    !osc_run |=> $stable(cnt) && $stable(tick_tgl));
endmodule

// File: rtl/toggle_sync.sv
module toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES-1:0] sh;
  logic last;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sh <= '0;
      last <= 1'b0;
    end else begin
      sh <= {sh[STAGES-2:0], tgl_in};
      last <= sh[STAGES-1];
    end
  end

  assign pulse = sh[STAGES-1] ^ last;

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg
  import sct_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wdt_ovf,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             set_pulse,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_en) nxt = wr_data;
    nxt[B_FLAG] = nxt[B_FLAG] | set_pulse;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) q <= RESET_VAL;
    else if (wdt_ovf) q <= RESET_VAL;
    else q <= nxt;
  end

  // R2
  wdt_reset_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_ovf |=> q == RESET_VAL);
  // R5
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_pulse && !wdt_ovf) |=> q[B_FLAG]);
  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(q[B_FLAG]) |-> $past(wdt_ovf) || ($past(wr_en) && !$past(wr_data[B_FLAG])));
endmodule

// File: rtl/sec_clock_ctrl.sv
module sec_clock_ctrl
  import sct_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wdt_ovf,
  input  logic             ref_clk,
  input  logic             osc_run,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ext_int1,
  output logic [REG_W-1:0] rd_data,
  output logic             osc_keep,
  output logic [FSEL_W-1:0] fsel,
  output logic             fsel_reserved,
  output logic             int1_req
);
  logic tgl;
  logic tick;
  logic [REG_W-1:0] r;

  sec_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .ref_clk(ref_clk), .rst(rst), .osc_run(osc_run), .tick_tgl(tgl));

  toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .tgl_in(tgl), .pulse(tick));

  clkctl_reg u_reg (
    .clk(clk), .rst(rst), .wdt_ovf(wdt_ovf), .wr_en(wr_en),
    .wr_data(wr_data), .set_pulse(tick), .q(r));

  assign rd_data = r;
  assign osc_keep = r[B_KEEP];
  assign fsel = r[FSEL_W-1:0];
  assign fsel_reserved = fsel_is_reserved(r[FSEL_W-1:0]);
  assign int1_req = ext_int1 | (r[B_SEN] & r[B_FLAG]);

  // R6
  int1_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ext_int1 |-> int1_req);
endmodule

// File: tb/sec_clock_ctrl_test.sv
module sec_clock_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;

  logic clk = 0, rst = 1, wdt_ovf = 0, ref_clk = 0, osc_run = 0;
  logic wr_en = 0, ext_int1 = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic osc_keep, fsel_reserved, int1_req;
  logic [4:0] fsel;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_clock_ctrl #(.CNT_W(CW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .wdt_ovf(wdt_ovf), .ref_clk(ref_clk), .osc_run(osc_run),
    .wr_en(wr_en), .wr_data(wr_data), .ext_int1(ext_int1), .rd_data(rd_data),
    .osc_keep(osc_keep), .fsel(fsel), .fsel_reserved(fsel_reserved), .int1_req(int1_req));

  function automatic bit m_reserved(input logic [4:0] c);
    return !(c[4:2] inside {3'b010, 3'b011, 3'b100});
  endfunction

  function automatic bit m_int1(input logic [7:0] r, input bit e);
    return e | (r[6] & r[5]);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ref_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      #37 ref_clk = 1;
      #37 ref_clk = 0;
    end
  endtask

  task automatic check_reg(input logic [7:0] e, input string tag);
    chk(rd_data == e, tag, rd_data, e);
    chk(osc_keep == e[7] && fsel == e[4:0], {tag, " fields"}, {osc_keep, fsel}, {e[7], e[4:0]});
    chk(fsel_reserved == m_reserved(e[4:0]), "R8 reserved flag", fsel_reserved, m_reserved(e[4:0]));
    chk(int1_req == m_int1(e, ext_int1), "R6 int1_req", int1_req, m_int1(e, ext_int1));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog timeout");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R2 reset value
    check_reg(8'h0D, "R2 reset value");

    // R1 R8 R6 random writes, reference clock idle
    for (int i = 0; i < 40; i++) begin
      d = 8'($urandom);
      ext_int1 = 1'($urandom);
      write(d);
      check_reg(d, "R1 write readback");
    end
    ext_int1 = 0;

    // R8 directed reserved codes stored as written
    write(8'h1F); check_reg(8'h1F, "R8 reserved stored");
    write(8'h08); check_reg(8'h08, "R8 valid code 010");
    write(8'h13); check_reg(8'h13, "R8 valid code 100");

    // R5 software set and clear
    write(8'h20); check_reg(8'h20, "R5 sw set");
    write(8'h00); check_reg(8'h00, "R4 sw clear");

    // R6 enable gating
    write(8'h20); check_reg(8'h20, "R6 flag without enable");
    write(8'h60); check_reg(8'h60, "R6 flag with enable");
    write(8'h40); check_reg(8'h40, "R6 enable without flag");

    // R2 watchdog reset
    write(8'hE5);
    @(negedge clk); wdt_ovf = 1; wr_en = 1; wr_data = 8'hFF;
    @(negedge clk); wdt_ovf = 0; wr_en = 0;
    check_reg(8'h0D, "R2 watchdog reset");

    // R7 oscillator halted: no progress
    write(8'h00);
    osc_run = 0;
    ref_pulses(3 * (1 << CW));
    repeat (6) @(negedge clk);
    check_reg(8'h00, "R7 halted no flag");

    // R3 wrap exactly at 2^CW edges
    osc_run = 1;
    ref_pulses((1 << CW) - 1);
    repeat (6) @(negedge clk);
    check_reg(8'h00, "R3 no flag before wrap");
    ref_pulses(1);
    repeat (6) @(negedge clk);
    check_reg(8'h20, "R3 flag on wrap");

    // R4 flag persists
    osc_run = 0;
    repeat (20) @(negedge clk);
    check_reg(8'h20, "R4 flag persists");
    write(8'h24); check_reg(8'h24, "R4 write keeping flag");
    write(8'h04); check_reg(8'h04, "R4 write 0 clears");

    // R3 second wrap after halt and resume
    osc_run = 1;
    ref_pulses((1 << CW) - 1);
    repeat (6) @(negedge clk);
    check_reg(8'h04, "R3 no early second wrap");
    ref_pulses(1);
    repeat (6) @(negedge clk);
    check_reg(8'h24, "R3 second wrap");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule